// File: doc/BRIEF.md
# Station-Management Serial Master

This block turns single register accesses from a host into serial transactions on a two-wire management bus. The bus has a clock output and a data line, split here into an output, an output enable and an input. The host presents one request: a direction flag, a flag that selects the extended (two-frame) format, a 5-bit port address, a 21-bit register address and 16 bits of write data. The block accepts it while `ready_o` is high. When the transaction ends it pulses `done_o`, and for reads it also presents the returned 16-bit word and an error flag.

The management clock comes from the system clock. A divide value N gives an MDC period of 2N system clocks. A short access uses one 64-bit frame. An extended access sends two frames with one released idle bit between them. The first frame is an address frame that carries the low 16 address bits. The second frame is the read or write frame, and its register field carries the 5-bit device number. The block changes MDIO in the cycle where MDC falls and samples incoming bits at the rising MDC edge.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no access is in progress, `ready_o` is high, `mdc_o` is low and `mdio_oe_o` is low.
- R2: Every frame starts with 32 MDC cycles in which the block drives MDIO to 1.
- R3: A short-format frame sends, most significant bit first: start `01`, opcode `10` for a read or `01` for a write, the port address, then `req_addr_i[4:0]`.
- R4: An extended access first sends an address frame: start `00`, opcode `00`, the port, `req_addr_i[20:16]`, turnaround `10` and `req_addr_i[15:0]`. Then comes one MDC cycle with the line released. Then comes a second frame: start `00`, opcode `11` (read) or `01` (write), the port and `req_addr_i[20:16]`.
- R5: In a write frame the block drives turnaround `10` and then the 16 write-data bits MSB first. It holds `mdio_oe_o` high for all 64 bits.
- R6: In a read frame `mdio_oe_o` goes low from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround appear MSB first on `rdata_o` when `done_o` pulses.
- R7: In a read frame, if `mdio_i` is 1 at the rising edge of the second turnaround bit, `err_o` is 1 at `done_o`. Otherwise `err_o` is 0.
- R8: The MDC period is 2N system clocks for `div_i` = N. A value of 0 acts as 1.
- R9: `mdio_o` does not change while `mdc_o` stays high, so it is stable at every rising MDC edge.
- R10: `done_o` is a one-cycle pulse, one system clock after the falling MDC edge of the last bit: 64 MDC cycles for a short access, 129 for an extended one. A request presented while `ready_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | MDC half-period in system clocks |
| req_valid_i | input | 1 | Request strobe, taken when ready_o is high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_c45_i | input | 1 | 1 = extended two-frame access |
| req_port_i | input | 5 | Port address |
| req_addr_i | input | 21 | Register address; [20:16] device, [15:0] register for extended access |
| req_wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Idle and able to take a request |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rdata_o | output | 16 | Read data |
| err_o | output | 1 | Turnaround error on the last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The assertions assume that `div_i` stays constant from acceptance until `done_o`. The bench changes the divider only while `ready_o` is high. The assertions also assume that the request fields matter only in the accepting cycle, and the bench drives them just for that cycle, apart from one deliberate strobe during a busy access. The responder on `mdio_i` changes its value only while MDC is high, after the rising edge it follows, so each sampled bit is settled long before the next sampling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int TA_LAST    = 47;

    typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_GAP, PH_MAIN} phase_e;

    typedef struct packed {
        phase_e      ph;
        logic [5:0]  idx;
        logic [63:0] sh;
        logic        wr;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] wdata;
        logic [15:0] rd;
        logic        err;
        logic        done;
    } seq_t;

    // preamble, start, opcode, port, register field, turnaround, data
    function automatic logic [63:0] build_frame(logic [1:0] st, logic [1:0] op,
                                                logic [4:0] port, logic [4:0] fld,
                                                logic [15:0] data);
        return {32'hFFFF_FFFF, st, op, port, fld, 2'b10, data};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } cg_t;

    cg_t              cg_d, cg_q;
    logic [DIV_W-1:0] lim;
    logic             hit;

    always_comb begin
        lim    = (div_i == '0) ? DIV_W'(1) : div_i;
        hit    = en_i && (cg_q.cnt >= lim - DIV_W'(1));
        cg_d   = cg_q;
        rise_o = hit && !cg_q.mdc;
        fall_o = hit &&  cg_q.mdc;
        if (!en_i) begin
            cg_d.cnt = '0;
            cg_d.mdc = 1'b0;
        end else if (hit) begin
            cg_d.cnt = '0;
            cg_d.mdc = !cg_q.mdc;
        end else begin
            cg_d.cnt = cg_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

    assign mdc_o = cg_q.mdc;

    // R1
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !mdc_o);
    // R8
    half_period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $stable(div_i)) |-> (cg_q.cnt < lim));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid_i,
    input  logic        req_write_i,
    input  logic        req_c45_i,
    input  logic [4:0]  req_port_i,
    input  logic [20:0] req_addr_i,
    input  logic [15:0] req_wdata_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdc_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        ready_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        err_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid_i) begin
                    s_d.wr    = req_write_i;
                    s_d.port  = req_port_i;
                    s_d.wdata = req_wdata_i;
                    s_d.err   = 1'b0;
                    s_d.idx   = '0;
                    if (req_c45_i) begin
                        s_d.ph  = PH_ADDR;
                        s_d.dev = req_addr_i[20:16];
                        s_d.sh  = build_frame(2'b00, 2'b00, req_port_i,
                                              req_addr_i[20:16], req_addr_i[15:0]);
                    end else begin
                        s_d.ph  = PH_MAIN;
                        s_d.dev = req_addr_i[4:0];
                        s_d.sh  = build_frame(2'b01, req_write_i ? 2'b01 : 2'b10,
                                              req_port_i, req_addr_i[4:0], req_wdata_i);
                    end
                end
            end
            PH_ADDR: begin
                if (fall_i) begin
                    if (s_q.idx == 6'(FRAME_BITS - 1)) begin
                        s_d.ph  = PH_GAP;
                        s_d.idx = '0;
                    end else begin
                        s_d.idx = s_q.idx + 6'd1;
                        s_d.sh  = {s_q.sh[62:0], 1'b1};
                    end
                end
            end
            PH_GAP: begin
                if (fall_i) begin
                    s_d.ph  = PH_MAIN;
                    s_d.idx = '0;
                    s_d.sh  = build_frame(2'b00, s_q.wr ? 2'b01 : 2'b11,
                                          s_q.port, s_q.dev, s_q.wdata);
                end
            end
            default: begin
                if (rise_i && !s_q.wr) begin
                    if (s_q.idx == 6'(TA_LAST)) s_d.err = mdio_i;
                    if (s_q.idx > 6'(TA_LAST))  s_d.rd  = {s_q.rd[14:0], mdio_i};
                end
                if (fall_i) begin
                    if (s_q.idx == 6'(FRAME_BITS - 1)) begin
                        s_d.ph   = PH_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 6'd1;
                        s_d.sh  = {s_q.sh[62:0], 1'b1};
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.ph)
            PH_ADDR: mdio_oe_o = 1'b1;
            PH_MAIN: mdio_oe_o = s_q.wr || (s_q.idx < 6'(TA_FIRST));
            default: mdio_oe_o = 1'b0;
        endcase
    end

    assign mdio_o  = s_q.sh[63];
    assign busy_o  = (s_q.ph != PH_IDLE);
    assign ready_o = (s_q.ph == PH_IDLE);
    assign done_o  = s_q.done;
    assign rdata_o = s_q.rd;
    assign err_o   = s_q.err;

    // R9
    data_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_i && $past(mdc_i)) |-> $stable(mdio_o));
    // R1
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !mdc_i);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4
    gap_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ph == PH_GAP) |-> ($past(s_q.ph) == PH_ADDR));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             req_c45_i,
    input  logic [4:0]       req_port_i,
    input  logic [20:0]      req_addr_i,
    input  logic [15:0]      req_wdata_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [15:0]      rdata_o,
    output logic             err_o,
    output logic             mdc_o,
    output logic             mdio_o,
    output logic             mdio_oe_o,
    input  logic             mdio_i
);
    logic busy, rise, fall;

    mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .div_i  (div_i),
        .mdc_o  (mdc_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_c45_i   (req_c45_i),
        .req_port_i  (req_port_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .rise_i      (rise),
        .fall_i      (fall),
        .mdc_i       (mdc_o),
        .mdio_i      (mdio_i),
        .busy_o      (busy),
        .ready_o     (ready_o),
        .done_o      (done_o),
        .rdata_o     (rdata_o),
        .err_o       (err_o),
        .mdio_o      (mdio_o),
        .mdio_oe_o   (mdio_oe_o)
    );
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_i = 8'd2;
    logic             req_valid_i = 1'b0, req_write_i = 1'b0, req_c45_i = 1'b0;
    logic [4:0]       req_port_i = '0;
    logic [20:0]      req_addr_i = '0;
    logic [15:0]      req_wdata_i = '0;
    logic             ready_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0]      rdata_o;
    logic             mdio_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.DIV_W(DIV_W)) dut_i (.*);

    typedef struct {
        logic [0:128] b;
        logic [0:128] oe;
        int           n;
        bit           wr;
        bit           c45;
        logic [15:0]  rdata;
        logic         err;
        int           lim;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0, n_bad = 0;

    logic cap_b [0:255];
    logic cap_oe[0:255];
    int   rise_cnt = 0, rise_t1 = 0, rise_t2 = 0, cyc = 0, unstable = 0;
    logic mdc_prev = 1'b0, mdio_prev = 1'b0;

    int          resp_base = 0;
    logic [15:0] resp_data = '0;
    logic        resp_bad  = 1'b0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // responder: index of the upcoming bit is rise_cnt
    always_comb begin
        int k;
        k = rise_cnt - resp_base;
        if (k == 47)                mdio_i = resp_bad;
        else if (k >= 48 && k < 64) mdio_i = resp_data[63 - k];
        else                        mdio_i = 1'b1;
    end

    // monitor and scoreboard
    always @(negedge clk) begin
        cyc++;
        if (mdc_o && !mdc_prev) begin
            if (rise_cnt < 256) begin
                cap_b[rise_cnt]  = mdio_o;
                cap_oe[rise_cnt] = mdio_oe_o;
            end
            if (rise_cnt == 1) rise_t1 = cyc;
            if (rise_cnt == 2) rise_t2 = cyc;
            rise_cnt++;
        end
        if (mdc_o && mdc_prev && mdio_o !== mdio_prev) unstable++;
        mdc_prev  = mdc_o;
        mdio_prev = mdio_o;
        if (done_o) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                int pre_bad, hdr_bad, dat_bad, oe_bad;
                e = exp_q.pop_front();
                pre_bad = 0; hdr_bad = 0; dat_bad = 0; oe_bad = 0;
                for (int k = 0; k < e.n && k < 256; k++) begin
                    int  j;
                    bit  first;
                    first = e.c45 && k < 65;
                    j = (e.c45 && k >= 65) ? k - 65 : k;
                    if (e.oe[k] !== cap_oe[k]) begin
                        if (first) hdr_bad++; else oe_bad++;
                    end else if (e.oe[k] && cap_b[k] !== e.b[k]) begin
                        if (j < 32)              pre_bad++;
                        else if (first || j < 46) hdr_bad++;
                        else                      dat_bad++;
                    end
                end
                chk(rise_cnt == e.n, "R10", "MDC cycles per access", rise_cnt, e.n);
                chk(pre_bad == 0, "R2", "preamble bit errors", pre_bad, 0);
                chk(hdr_bad == 0, e.c45 ? "R4" : "R3", "header bit errors", hdr_bad, 0);
                if (e.wr) begin
                    chk(dat_bad == 0, "R5", "turnaround/data bit errors", dat_bad, 0);
                    chk(oe_bad == 0, "R5", "enable errors in write frame", oe_bad, 0);
                end else begin
                    chk(oe_bad == 0, "R6", "enable errors in read frame", oe_bad, 0);
                    chk(rdata_o == e.rdata, "R6", "read data", rdata_o, e.rdata);
                    chk(err_o == e.err, "R7", "turnaround error flag", err_o, e.err);
                end
                chk(rise_t2 - rise_t1 == 2 * e.lim, "R8", "MDC period", rise_t2 - rise_t1, 2 * e.lim);
                chk(unstable == 0, "R9", "data changes while MDC high", unstable, 0);
            end
        end
    end

    function automatic logic [0:63] frm(logic [1:0] st, logic [1:0] op, logic [4:0] p,
                                        logic [4:0] r, logic [15:0] d);
        return {32'hFFFF_FFFF, st, op, p, r, 2'b10, d};
    endfunction

    task automatic access(bit wr, bit c45, logic [4:0] port, logic [20:0] addr,
                          logic [15:0] wdata, logic [15:0] rresp, bit tabad,
                          logic [7:0] div, bit poke);
        exp_t        e;
        logic [0:63] fa, fm, oe_w, oe_r;
        oe_w = '1;
        oe_r = {{46{1'b1}}, {18{1'b0}}};
        if (c45) begin
            fa   = frm(2'b00, 2'b00, port, addr[20:16], addr[15:0]);
            fm   = frm(2'b00, wr ? 2'b01 : 2'b11, port, addr[20:16], wdata);
            e.b  = {fa, 1'b0, fm};
            e.oe = {oe_w, 1'b0, wr ? oe_w : oe_r};
            e.n  = 129;
            resp_base = 65;
        end else begin
            fm   = frm(2'b01, wr ? 2'b01 : 2'b10, port, addr[4:0], wdata);
            e.b  = {fm, 65'b0};
            e.oe = {wr ? oe_w : oe_r, 65'b0};
            e.n  = 64;
            resp_base = 0;
        end
        e.wr = wr; e.c45 = c45; e.rdata = rresp; e.err = wr ? 1'b0 : tabad;
        e.lim = (div == 0) ? 1 : int'(div);
        exp_q.push_back(e);
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        resp_data = rresp; resp_bad = tabad; div_i = div;
        rise_cnt = 0; unstable = 0;
        req_write_i = wr; req_c45_i = c45; req_port_i = port;
        req_addr_i = addr; req_wdata_i = wdata; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            // R10: strobe while busy with other fields; must be ignored
            req_write_i = !wr; req_c45_i = 1'b1; req_port_i = ~port;
            req_addr_i = ~addr; req_wdata_i = ~wdata; req_valid_i = 1'b1;
            @(negedge clk);
            req_valid_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        chk(!done_o, "R10", "done pulse width", done_o, 0);
        chk(ready_o && !mdc_o && !mdio_oe_o, "R1", "idle after access",
            {ready_o, mdc_o, mdio_oe_o}, 3'b100);
        if (poke) begin
            repeat (12) @(negedge clk);
            chk(rise_cnt == e.n && !mdc_o, "R10", "busy-time request ignored", rise_cnt, e.n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ready_o && !mdc_o && !mdio_oe_o && !done_o, "R1", "reset state",
            {ready_o, mdc_o, mdio_oe_o, done_o}, 4'b1000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready_o && !mdc_o && !mdio_oe_o, "R1", "idle after reset",
            {ready_o, mdc_o, mdio_oe_o}, 3'b100);
        access(1, 0, 5'h13, 21'h0000A, 16'hA5C3, 16'h0000, 0, 8'd2, 0); // R3 R5
        access(0, 0, 5'h0C, 21'h00015, 16'h0000, 16'h3C5A, 0, 8'd3, 0); // R3 R6
        access(0, 0, 5'h01, 21'h0001F, 16'h0000, 16'hFFFF, 1, 8'd2, 0); // R7
        access(1, 1, 5'h02, 21'h1DBEEF, 16'h1234, 16'h0000, 0, 8'd1, 0); // R4 R5
        access(0, 1, 5'h1E, 21'h0A8001, 16'h0000, 16'h8001, 0, 8'd0, 0); // R4 R6 R8
        access(1, 0, 5'h07, 21'h00003, 16'h0F0F, 16'h0000, 0, 8'd2, 1); // R10
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule